// File: doc/BRIEF.md
# Dual-Path Video Exchange and Overlay

This block sits after two parallel pixel-processing paths and in front of the two panel data outputs. The two paths are never perfectly matched, so the block routes them to the outputs through a crossbar whose setting flips from one line to the next. The flip pattern also inverts from frame to frame. Averaged over space and time, each output position sees both paths equally often, and any gain or offset difference between them cancels out.

After the crossbar, each pixel is keyed against an on-screen-display input. Where the key is active, the pixel is replaced by the display colour. A programmable window then forces pixels in the top, bottom, left and right margins to the blank level. Panel timing arrives as a frame-start pulse, a line-start pulse and a data-enable level. The block counts pixels and lines from these itself. A small write-only register bus sets the four margin sizes and three enable bits. Every output, including the delayed timing signals, is registered with exactly one cycle of latency.

Top module: `dual_path_xchg`

## Requirements
- R1: While reset is asserted and on the first edge after it, both pixel outputs and the three delayed timing outputs are zero. All configuration fields reset to zero.
- R2: A bus write with `bus_wr` high stores `bus_wdata` into the register at `bus_addr`. The addresses are 0 = top margin, 1 = bottom margin, 2 = left margin, 3 = right margin, and 4 = control. In the control register, bit 0 enables the display overlay, bit 1 enables the margins and bit 2 disables the exchange. The new value governs pixels from the cycle after the write. Addresses 5 to 7 change nothing.
- R3: The pixel index of a data-enable cycle is the number of data-enable cycles since the last line-start or frame-start pulse. The pulse cycle itself counts as index 0. The line index starts at 0 at a frame-start pulse. It advances by one at a line-start pulse only if the line just ended held at least one data-enable cycle. Both counters saturate at 2047.
- R4: The exchange select is line-index bit 0 XOR the frame parity. With select 0, `out0` carries path A and `out1` carries path B. With select 1, the paths are crossed.
- R5: The frame parity is 0 after reset and inverts at every frame-start pulse. The pulse cycle already uses the new parity.
- R6: With the exchange disabled, the select is held at 0 on every line and frame.
- R7: With the overlay enabled and `osd_key` high on a data-enable cycle, both outputs carry `osd_rgb`.
- R8: With the margins enabled, a pixel is blanked (all zero) when line < top, or line + bottom >= V_ACT, or pixel < left, or pixel + right >= H_ACT.
- R9: Priority runs from highest to lowest: data-enable low gives zero, then margin blanking, then overlay, then exchanged video.
- R10: Pixel outputs lag the inputs by one cycle. `de_out`, `frame_start_out` and `line_start_out` carry the inputs delayed by the same single cycle.
- R11: A margin value at or above the active size blanks every line, or every pixel, with no wrap-around in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 11 | Register write data |
| frame_start | input | 1 | Frame-start pulse |
| line_start | input | 1 | Line-start pulse |
| de_in | input | 1 | Data enable |
| path_a | input | 30 | Path A pixel, three 10-bit components |
| path_b | input | 30 | Path B pixel, three 10-bit components |
| osd_key | input | 1 | Overlay key for this pixel |
| osd_rgb | input | 30 | Overlay colour |
| out0 | output | 30 | Panel output 0 pixel |
| out1 | output | 30 | Panel output 1 pixel |
| de_out | output | 1 | Delayed data enable |
| frame_start_out | output | 1 | Delayed frame-start pulse |
| line_start_out | output | 1 | Delayed line-start pulse |

## Verification
The bench runs video before the first frame pulse, then frames with empty lines and data-enable gaps inside lines. A design that advanced the line count on an empty line, or the pixel count during a gap, would misplace the margins and flip the crossbar on the wrong line. Margins exactly at the active size, and margins far larger than it, are both driven. A wrapping adder there would let the far-oversized case show video instead of blanking. Frames with overlay and margins on together expose a swapped priority, and frames with the exchange disabled expose a select that still follows frame parity.

// File: rtl/pxo_pkg.sv
package pxo_pkg;
    localparam int BW     = 11;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_TOP  = 3'd0;
    localparam logic [ADDR_W-1:0] A_BOT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LFT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_RGT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;

    typedef struct packed {
        logic [BW-1:0] top;
        logic [BW-1:0] bot;
        logic [BW-1:0] lft;
        logic [BW-1:0] rgt;
        logic          osd_en;
        logic          blank_en;
        logic          swap_dis;
    } cfg_t;
endpackage

// File: rtl/pxo_regs.sv
module pxo_regs
    import pxo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BW-1:0]     wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (addr)
                A_TOP:  cfg_d.top = wdata;
                A_BOT:  cfg_d.bot = wdata;
                A_LFT:  cfg_d.lft = wdata;
                A_RGT:  cfg_d.rgt = wdata;
                A_CTRL: begin
                    cfg_d.osd_en   = wdata[0];
                    cfg_d.blank_en = wdata[1];
                    cfg_d.swap_dis = wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R2: without a write strobe the configuration keeps its value
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> cfg_q == $past(cfg_q));
endmodule

// File: rtl/pxo_raster.sv
module pxo_raster
    import pxo_pkg::*;
#(
    parameter int H_ACT = 1024,
    parameter int V_ACT = 768
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fstart,
    input  logic          lstart,
    input  logic          de,
    input  logic [BW-1:0] top,
    input  logic [BW-1:0] bot,
    input  logic [BW-1:0] lft,
    input  logic [BW-1:0] rgt,
    input  logic          swap_dis,
    output logic          sel,
    output logic          in_border
);
    localparam logic [BW-1:0] CMAX  = '1;
    localparam logic [BW:0]   H_LIM = (BW+1)'(H_ACT);
    localparam logic [BW:0]   V_LIM = (BW+1)'(V_ACT);

    typedef struct packed {
        logic [BW-1:0] line;
        logic [BW-1:0] pix;
        logic          act;
        logic          frame;
    } rst_t;

    rst_t st_d, st_q;
    logic [BW-1:0] cur_line, cur_pix, line_inc, pix_inc;
    logic          cur_frame;
    logic [BW:0]   line_far, pix_far;

    always_comb begin
        line_inc  = (st_q.line == CMAX) ? CMAX : st_q.line + 1'b1;
        pix_inc   = (st_q.pix == CMAX) ? CMAX : st_q.pix + 1'b1;
        cur_frame = fstart ? ~st_q.frame : st_q.frame;
        if (fstart)                   cur_line = '0;
        else if (lstart && st_q.act)  cur_line = line_inc;
        else                          cur_line = st_q.line;
        cur_pix = (fstart || lstart) ? '0 : st_q.pix;

        st_d = st_q;
        if (fstart || lstart) begin
            st_d.line = cur_line;
            st_d.act  = de;
            st_d.pix  = de ? BW'(1) : '0;
            if (fstart) st_d.frame = ~st_q.frame;
        end else if (de) begin
            st_d.pix = pix_inc;
            st_d.act = 1'b1;
        end

        line_far  = {1'b0, cur_line} + {1'b0, bot};
        pix_far   = {1'b0, cur_pix} + {1'b0, rgt};
        in_border = (cur_line < top) || (line_far >= V_LIM) ||
                    (cur_pix < lft)  || (pix_far >= H_LIM);
        sel       = swap_dis ? 1'b0 : (cur_line[0] ^ cur_frame);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: every frame pulse inverts the stored parity
    p_frame_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fstart |=> st_q.frame != $past(st_q.frame));
    // R3: between pulses the pixel count never goes backwards
    p_pix_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fstart && !lstart) |=> st_q.pix >= $past(st_q.pix));
    // R3: the line count only moves on a pulse
    p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fstart && !lstart) |=> st_q.line == $past(st_q.line));
    // R6: a disabled exchange keeps the select at zero
    p_swap_fix_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swap_dis |-> !sel);
endmodule

// File: rtl/pxo_out.sv
module pxo_out #(
    parameter int PW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pa,
    input  logic [PW-1:0] pb,
    input  logic [PW-1:0] osd_rgb,
    input  logic          osd_key,
    input  logic          de,
    input  logic          fstart,
    input  logic          lstart,
    input  logic          sel,
    input  logic          in_border,
    input  logic          osd_en,
    input  logic          blank_en,
    output logic [PW-1:0] o0,
    output logic [PW-1:0] o1,
    output logic          de_o,
    output logic          fs_o,
    output logic          ls_o
);
    localparam int NOUT = 2;

    typedef struct packed {
        logic [NOUT-1:0][PW-1:0] px;
        logic                    de;
        logic                    fs;
        logic                    ls;
    } ost_t;

    ost_t st_d, st_q;
    logic [NOUT-1:0][PW-1:0] route;
    logic blank_hit, osd_hit;

    for (genvar g = 0; g < NOUT; g++) begin : g_route
        if (g == 0) begin : g_first
            assign route[g] = sel ? pb : pa;
        end else begin : g_second
            assign route[g] = sel ? pa : pb;
        end
    end

    always_comb begin
        blank_hit = blank_en && in_border;
        osd_hit   = osd_en && osd_key;
        st_d.de   = de;
        st_d.fs   = fstart;
        st_d.ls   = lstart;
        for (int i = 0; i < NOUT; i++) begin
            if (!de || blank_hit) st_d.px[i] = '0;
            else if (osd_hit)     st_d.px[i] = osd_rgb;
            else                  st_d.px[i] = route[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o0   = st_q.px[0];
    assign o1   = st_q.px[1];
    assign de_o = st_q.de;
    assign fs_o = st_q.fs;
    assign ls_o = st_q.ls;

    // R9: idle cycles produce zero on both outputs
    p_idle_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !de |=> (o0 == '0) && (o1 == '0));
    // R8: blanked margin pixels are zero even with the key active
    p_margin_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (de && blank_en && in_border) |=> (o0 == '0) && (o1 == '0));
    // R7: keyed pixels outside the margins carry the overlay colour
    p_osd_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (de && osd_en && osd_key && !(blank_en && in_border))
        |=> (o0 == $past(osd_rgb)) && (o1 == $past(osd_rgb)));
    // R4: plain video reaches the two outputs from opposite paths
    p_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (de && !(blank_en && in_border) && !(osd_en && osd_key))
        |=> (o0 == ($past(sel) ? $past(pb) : $past(pa))) &&
            (o1 == ($past(sel) ? $past(pa) : $past(pb))));
    // R10: the frame pulse appears on the output one cycle later
    p_fs_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fstart |=> fs_o);
endmodule

// File: rtl/dual_path_xchg.sv
module dual_path_xchg
    import pxo_pkg::*;
#(
    parameter int COMP_W = 10,
    parameter int H_ACT  = 1024,
    parameter int V_ACT  = 768,
    localparam int PW    = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              de_in,
    input  logic [PW-1:0]     path_a,
    input  logic [PW-1:0]     path_b,
    input  logic              osd_key,
    input  logic [PW-1:0]     osd_rgb,
    output logic [PW-1:0]     out0,
    output logic [PW-1:0]     out1,
    output logic              de_out,
    output logic              frame_start_out,
    output logic              line_start_out
);
    cfg_t cfg;
    logic sel, in_border;

    pxo_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    pxo_raster #(.H_ACT(H_ACT), .V_ACT(V_ACT)) u_raster (
        .clk       (clk),
        .rst_n     (rst_n),
        .fstart    (frame_start),
        .lstart    (line_start),
        .de        (de_in),
        .top       (cfg.top),
        .bot       (cfg.bot),
        .lft       (cfg.lft),
        .rgt       (cfg.rgt),
        .swap_dis  (cfg.swap_dis),
        .sel       (sel),
        .in_border (in_border)
    );

    pxo_out #(.PW(PW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pa        (path_a),
        .pb        (path_b),
        .osd_rgb   (osd_rgb),
        .osd_key   (osd_key),
        .de        (de_in),
        .fstart    (frame_start),
        .lstart    (line_start),
        .sel       (sel),
        .in_border (in_border),
        .osd_en    (cfg.osd_en),
        .blank_en  (cfg.blank_en),
        .o0        (out0),
        .o1        (out1),
        .de_o      (de_out),
        .fs_o      (frame_start_out),
        .ls_o      (line_start_out)
    );

    // R10: data enable is delayed by exactly one cycle
    p_de_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        de_out == $past(de_in));
    // R1: the first edge out of reset presents zeros
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (out0 == '0) && (out1 == '0) && !de_out);
endmodule

// File: tb/sim_dual_path_xchg.sv
module sim_dual_path_xchg;
    localparam int H = 16;
    localparam int V = 8;
    localparam int PW = 30;
    localparam int SAT = 2047;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [10:0] bus_wdata = '0;
    logic frame_start = 1'b0, line_start = 1'b0, de_in = 1'b0, osd_key = 1'b0;
    logic [PW-1:0] path_a = '0, path_b = '0, osd_rgb = '0;
    logic [PW-1:0] out0, out1;
    logic de_out, frame_start_out, line_start_out;

    dual_path_xchg #(.COMP_W(10), .H_ACT(H), .V_ACT(V)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .frame_start(frame_start), .line_start(line_start),
        .de_in(de_in), .path_a(path_a), .path_b(path_b), .osd_key(osd_key),
        .osd_rgb(osd_rgb), .out0(out0), .out1(out1), .de_out(de_out),
        .frame_start_out(frame_start_out), .line_start_out(line_start_out)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    int m_top, m_bot, m_lft, m_rgt, m_osd, m_blk, m_swp;
    int m_line, m_pix, m_act, m_frame;
    logic [PW-1:0] e0, e1;
    logic e_de, e_fs, e_ls;
    string e_tag;

    always @(posedge clk) begin
        int cl, cp, cf, sel;
        bit bord, big;
        if (!rst_n) begin
            m_top = 0; m_bot = 0; m_lft = 0; m_rgt = 0;
            m_osd = 0; m_blk = 0; m_swp = 0;
            m_line = 0; m_pix = 0; m_act = 0; m_frame = 0;
            e0 = '0; e1 = '0; e_de = 0; e_fs = 0; e_ls = 0;
            e_tag = "R1";
        end else begin
            if (frame_start) cl = 0;
            else if (line_start && m_act != 0) cl = (m_line < SAT) ? m_line + 1 : SAT;
            else cl = m_line;
            cp = (frame_start || line_start) ? 0 : m_pix;
            cf = frame_start ? (m_frame ^ 1) : m_frame;
            bord = (cl < m_top) || (cl + m_bot >= V) || (cp < m_lft) || (cp + m_rgt >= H);
            big = (m_top >= V) || (m_bot >= V) || (m_lft >= H) || (m_rgt >= H);
            sel = (m_swp != 0) ? 0 : ((cl % 2) ^ cf);
            e_de = de_in; e_fs = frame_start; e_ls = line_start;
            if (!de_in) begin
                e0 = '0; e1 = '0; e_tag = "R9";
            end else if (m_blk != 0 && bord) begin
                e0 = '0; e1 = '0;
                e_tag = big ? "R11 R8" : ((m_osd != 0 && osd_key) ? "R9 R8 R3" : "R8 R3");
            end else if (m_osd != 0 && osd_key) begin
                e0 = osd_rgb; e1 = osd_rgb; e_tag = "R7 R2";
            end else begin
                e0 = (sel != 0) ? path_b : path_a;
                e1 = (sel != 0) ? path_a : path_b;
                e_tag = (m_swp != 0) ? "R6" : "R4 R5 R3";
            end
            if (frame_start || line_start) begin
                m_line = cl;
                m_act = de_in ? 1 : 0;
                m_pix = de_in ? 1 : 0;
                if (frame_start) m_frame = m_frame ^ 1;
            end else if (de_in) begin
                m_pix = (m_pix < SAT) ? m_pix + 1 : SAT;
                m_act = 1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_top = int'(bus_wdata);
                    3'd1: m_bot = int'(bus_wdata);
                    3'd2: m_lft = int'(bus_wdata);
                    3'd3: m_rgt = int'(bus_wdata);
                    3'd4: begin
                        m_osd = int'(bus_wdata[0]);
                        m_blk = int'(bus_wdata[1]);
                        m_swp = int'(bus_wdata[2]);
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic check_outs();
        n_chk++;
        if (out0 !== e0 || out1 !== e1) begin
            n_fail++;
            $display("FAIL %s pixels: out0=%h out1=%h expected %h %h", e_tag, out0, out1, e0, e1);
        end
        n_chk++;
        if (de_out !== e_de || frame_start_out !== e_fs || line_start_out !== e_ls) begin
            n_fail++;
            $display("FAIL R10 timing: de/fs/ls=%b%b%b expected %b%b%b",
                     de_out, frame_start_out, line_start_out, e_de, e_fs, e_ls);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_outs();
    endtask

    task automatic cyc(input bit f, input bit l, input bit d, input bit k);
        tick();
        frame_start = f; line_start = l; de_in = d; osd_key = k;
        path_a = PW'($urandom); path_b = PW'($urandom); osd_rgb = PW'($urandom);
        bus_wr = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        cyc(0, 0, 0, 0);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 11'(d);
    endtask

    task automatic one_line(input int gap);
        cyc(0, 1, 0, 0);
        for (int px = 0; px < H; px++) begin
            cyc(0, 0, 1, (px % 3) == 0);
            if (px == gap) cyc(0, 0, 0, 1);
        end
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
    endtask

    task automatic one_frame();
        cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
        for (int ln = 0; ln < V; ln++) begin
            one_line(ln + 2);
            if (ln == 3) begin
                cyc(0, 1, 0, 0);   // empty line: R3 line count must not move
                cyc(0, 0, 0, 0);
            end
        end
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) cyc(0, 0, 0, 0);      // R1 reset-state checks
        rst_n = 1'b1;
        cyc(0, 0, 0, 0);
        one_line(5);                     // frame 0 before any frame pulse
        one_frame();                     // default config, exchange active
        one_frame();
        wr(0, 1); wr(1, 1); wr(2, 2); wr(3, 3);
        wr(6, 2047);                     // unused address, no effect (R2)
        wr(4, 3'b010);
        one_frame();                     // margins
        wr(4, 3'b011);
        one_frame();                     // margins plus overlay, priority
        wr(4, 3'b111);
        one_frame();                     // exchange disabled
        wr(4, 3'b011);
        wr(0, 2047);
        one_frame();                     // oversized top, R11
        wr(0, 0); wr(1, V); wr(2, 0); wr(3, 0);
        one_frame();                     // bottom equal to active height
        wr(1, 0); wr(2, 2000);
        one_frame();                     // oversized left
        wr(2, 0); wr(3, H);
        one_frame();                     // right equal to active width
        wr(3, 2047);
        one_frame();                     // far-oversized right, no wrap
        wr(3, 0); wr(4, 3'b001);
        one_frame();
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule